// File: doc/BRIEF.md
# Channel Address Compaction Unit

Once an upstream decoder has picked a memory channel and a decode rule for a system address, this block turns that address into the dense address that the channel itself sees. Each (channel, rule) pair has its own settings. A signed offset, counted in 64 KiB units, moves the address window. Up to three low line-index bits that were spent on interleaving can be squeezed out, and a divide-by-3 step can shrink the line index when a three-way interleave is in use. When the channels run in lockstep or mirrored, every request uses channel 0's settings.

Requests arrive as an address, a channel index and a rule index, marked by a valid flag. The block is fully pipelined and accepts one request per clock. Each result leaves with its own valid flag after a fixed latency of `DIV_STAGES + 2` cycles. The divide-by-3 is a restoring constant divider spread over `DIV_STAGES` register stages.

Top module: `chan_addr_compact`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is low.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, `DIV_STAGES + 2` clock edges later. Results keep input order, and back-to-back inputs give back-to-back outputs.
- R3: The first step adds the two's-complement offset of the selected entry to address bits above bit 16 and puts the sum back at bit 16. Address bits 15:6 are kept and bits 5:0 become zero. With a zero offset and no removal or division, the result is the input address bits 36:6 with bits 5:0 cleared.
- R4: The removal enables are bit 2 (bit 8), bit 1 (bit 7) and bit 0 (bit 6) of the entry's 3-bit field in `cfg_remove`. They act in the order bit 8, then bit 7, then bit 6. Removing bit N moves every bit above N down one place and leaves bits N-1:0 unchanged.
- R5: After the removals, the value is cut to its low 37 bits. Higher bits, including those produced by a negative offset sum, do not appear in `out_addr`.
- R6: When the entry's `cfg_div3` bit is set, bits 36:6 of the result become their value divided by 3, rounded down, and bits 5:0 are kept.
- R7: When `fold_en` is high, the settings of channel 0 for the given rule are used, whatever the value of `in_chan`.
- R8: A channel index of `NCH` or above selects channel 0's settings.
- R9: The settings for channel c and rule r form entry e = c*NRULE + r. Its offset is `cfg_offset[e*OFF_W +: OFF_W]`, its removal field is `cfg_remove[e*3 +: 3]` and its divide bit is `cfg_div3[e]`. All are sampled in the same cycle as the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_addr | input | ADDR_W | System address |
| in_chan | input | CHI_W | Logical channel index |
| in_rule | input | RULE_W | Decode rule index |
| fold_en | input | 1 | Lockstep or mirror mode: use channel 0 settings |
| cfg_offset | input | NENT*OFF_W | Signed per-entry offsets in 64 KiB units |
| cfg_remove | input | NENT*3 | Per-entry bit removal enables |
| cfg_div3 | input | NENT | Per-entry divide-by-3 enables |
| out_valid | output | 1 | Result present |
| out_addr | output | CH_W | Channel address |

## Verification
The assertions assume that the configuration vectors and `fold_en` hold steady over each clock edge at which `in_valid` is sampled, and that `in_valid` is low or at a defined level whenever reset is released. The in-flight count check also assumes that every accepted request drains without stalls, because the block has no back-pressure. The stimulus changes configuration and fold mode only at falling edges, and only in cycles in which `in_valid` is driven low. It drives every request at a falling edge, so each value is settled long before the rising edge that captures it.

// File: rtl/cac_pkg.sv
package cac_pkg;
  typedef struct packed {
    logic drop8;
    logic drop7;
    logic drop6;
    logic div3;
  } cac_mode_t;

  localparam int unsigned LINE_LSB = 6;
  localparam int unsigned SEG_LSB  = 16;
  localparam int unsigned NDROP    = 3;
endpackage

// File: rtl/cac_cfg_select.sv
module cac_cfg_select
  import cac_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int NRULE  = 8,
  parameter int OFF_W  = 14,
  parameter int ADDR_W = 40,
  localparam int NENT   = NCH * NRULE,
  localparam int CHI_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RULE_W = (NRULE > 1) ? $clog2(NRULE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [CHI_W-1:0]      in_chan,
  input  logic [RULE_W-1:0]     in_rule,
  input  logic                  fold_en,
  input  logic [NENT*OFF_W-1:0] cfg_offset,
  input  logic [NENT*NDROP-1:0] cfg_remove,
  input  logic [NENT-1:0]       cfg_div3,
  output logic                  s_valid,
  output logic [ADDR_W-1:0]     s_addr,
  output logic [OFF_W-1:0]      s_off,
  output cac_mode_t             s_mode
);
  logic [CHI_W-1:0] eff_chan;
  int               sel_idx;
  logic [NDROP-1:0] sel_rm;

  // Out-of-range channels and fold mode both fall back to channel 0 (R7, R8)
  always_comb begin
    eff_chan = in_chan;
    if (fold_en || (int'(in_chan) >= NCH)) eff_chan = '0;
    sel_idx = int'(eff_chan) * NRULE + int'(in_rule);
    sel_rm  = cfg_remove[sel_idx*NDROP +: NDROP];
  end

  always_ff @(posedge clk) begin
    if (rst) s_valid <= 1'b0;
    else     s_valid <= in_valid;
    if (in_valid) begin
      s_addr      <= in_addr;
      s_off       <= cfg_offset[sel_idx*OFF_W +: OFF_W];
      s_mode.drop8 <= sel_rm[2];
      s_mode.drop7 <= sel_rm[1];
      s_mode.drop6 <= sel_rm[0];
      s_mode.div3  <= cfg_div3[sel_idx];
    end
  end

  // Channel-0 view of the current rule, used only by the assertion
  logic [OFF_W-1:0] ch0_off;
  logic             ch0_div;
  always_comb begin
    ch0_off = cfg_offset[int'(in_rule)*OFF_W +: OFF_W];
    ch0_div = cfg_div3[int'(in_rule)];
  end

  assert_fold_chan0_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fold_en) |=> (s_off == $past(ch0_off) && s_mode.div3 == $past(ch0_div)));
endmodule

// File: rtl/cac_squeeze.sv
module cac_squeeze
  import cac_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFF_W  = 14,
  parameter int CH_W   = 37,
  localparam int UP_W   = ADDR_W - SEG_LSB,
  localparam int LINE_W = CH_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [OFF_W-1:0]  s_off,
  input  cac_mode_t         s_mode,
  output logic              c_valid,
  output logic [LINE_W-1:0] c_line,
  output logic              c_div
);
  logic [UP_W-1:0]   seg_sum;
  logic [NDROP-1:0]  drop_en;
  logic [ADDR_W-1:0] chain [NDROP+1];

  // Segment relocation in 64 KiB units (R3)
  assign seg_sum  = s_addr[ADDR_W-1:SEG_LSB] + {{(UP_W-OFF_W){s_off[OFF_W-1]}}, s_off};
  assign chain[0] = {seg_sum, s_addr[SEG_LSB-1:LINE_LSB], {LINE_LSB{1'b0}}};
  // Step k removes bit 8-k: bit 8 first, bit 6 last (R4)
  assign drop_en  = {s_mode.drop6, s_mode.drop7, s_mode.drop8};

  for (genvar k = 0; k < NDROP; k++) begin : g_drop
    localparam int POS = 8 - k;
    assign chain[k+1] = drop_en[k]
      ? {1'b0, chain[k][ADDR_W-1:POS+1], chain[k][POS-1:0]}
      : chain[k];
  end

  always_ff @(posedge clk) begin
    if (rst) c_valid <= 1'b0;
    else     c_valid <= s_valid;
    if (s_valid) begin
      c_line <= chain[NDROP][CH_W-1:LINE_LSB];  // 37-bit cut (R5)
      c_div  <= s_mode.div3;
    end
  end

  assert_zero_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_off == '0 && !s_mode.drop8 && !s_mode.drop7 && !s_mode.drop6)
      |=> (c_line == $past(s_addr[CH_W-1:LINE_LSB])));
endmodule

// File: rtl/cac_div3_pipe.sv
module cac_div3_pipe #(
  parameter int LINE_W = 31,
  parameter int STAGES = 4,
  localparam int BPS   = (LINE_W + STAGES - 1) / STAGES,
  localparam int PAD_W = BPS * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [LINE_W-1:0] d_line,
  input  logic              d_div,
  output logic              o_valid,
  output logic [LINE_W-1:0] o_line
);
  logic              v_r   [1:STAGES];
  logic              dv_r  [1:STAGES];
  logic [LINE_W-1:0] src_r [1:STAGES];
  logic [PAD_W-1:0]  q_r   [1:STAGES];
  logic [1:0]        rem_r [1:STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic              in_v, in_dv;
    logic [LINE_W-1:0] in_src;
    logic [PAD_W-1:0]  in_q, q_nx, num;
    logic [1:0]        in_rem, r_nx;
    logic [2:0]        acc;

    if (s == 0) begin : g_head
      assign in_v   = d_valid;
      assign in_dv  = d_div;
      assign in_src = d_line;
      assign in_q   = '0;
      assign in_rem = 2'd0;
    end else begin : g_body
      assign in_v   = v_r[s];
      assign in_dv  = dv_r[s];
      assign in_src = src_r[s];
      assign in_q   = q_r[s];
      assign in_rem = rem_r[s];
    end

    // Restoring division by 3 over BPS dividend bits, MSB first (R6)
    always_comb begin
      num  = PAD_W'(in_src);
      q_nx = in_q;
      r_nx = in_rem;
      acc  = 3'd0;
      for (int b = 0; b < BPS; b++) begin
        acc = {r_nx, num[PAD_W-1-s*BPS-b]};
        if (acc >= 3'd3) begin
          q_nx[PAD_W-1-s*BPS-b] = 1'b1;
          r_nx = 2'(acc - 3'd3);
        end else begin
          q_nx[PAD_W-1-s*BPS-b] = 1'b0;
          r_nx = acc[1:0];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) v_r[s+1] <= 1'b0;
      else     v_r[s+1] <= in_v;
      if (in_v) begin
        dv_r[s+1]  <= in_dv;
        src_r[s+1] <= in_src;
        q_r[s+1]   <= q_nx;
        rem_r[s+1] <= r_nx;
      end
    end

    assert_rem_range_R6: assert property (@(posedge clk) disable iff (rst)
      v_r[s+1] |-> (rem_r[s+1] != 2'd3));
  end

  assign o_valid = v_r[STAGES];
  assign o_line  = dv_r[STAGES] ? q_r[STAGES][LINE_W-1:0] : src_r[STAGES];

  logic [PAD_W+1:0] recon;
  assign recon = (PAD_W+2)'(q_r[STAGES]) * (PAD_W+2)'(3) + (PAD_W+2)'(rem_r[STAGES]);

  assert_quot_identity_R6: assert property (@(posedge clk) disable iff (rst)
    v_r[STAGES] |-> (recon == (PAD_W+2)'(src_r[STAGES])));
endmodule

// File: rtl/chan_addr_compact.sv
module chan_addr_compact
  import cac_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int NRULE      = 8,
  parameter int ADDR_W     = 40,
  parameter int CH_W       = 37,
  parameter int OFF_W      = 14,
  parameter int DIV_STAGES = 4,
  localparam int NENT    = NCH * NRULE,
  localparam int CHI_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RULE_W  = (NRULE > 1) ? $clog2(NRULE) : 1,
  localparam int LINE_W  = CH_W - LINE_LSB,
  localparam int LATENCY = DIV_STAGES + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [CHI_W-1:0]      in_chan,
  input  logic [RULE_W-1:0]     in_rule,
  input  logic                  fold_en,
  input  logic [NENT*OFF_W-1:0] cfg_offset,
  input  logic [NENT*3-1:0]     cfg_remove,
  input  logic [NENT-1:0]       cfg_div3,
  output logic                  out_valid,
  output logic [CH_W-1:0]       out_addr
);
  logic              s_valid;
  logic [ADDR_W-1:0] s_addr;
  logic [OFF_W-1:0]  s_off;
  cac_mode_t         s_mode;
  logic              c_valid, c_div;
  logic [LINE_W-1:0] c_line, o_line;

  cac_cfg_select #(.NCH(NCH), .NRULE(NRULE), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_chan(in_chan), .in_rule(in_rule), .fold_en(fold_en),
    .cfg_offset(cfg_offset), .cfg_remove(cfg_remove), .cfg_div3(cfg_div3),
    .s_valid(s_valid), .s_addr(s_addr), .s_off(s_off), .s_mode(s_mode)
  );

  cac_squeeze #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CH_W(CH_W)) u_sqz (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_addr(s_addr), .s_off(s_off),
    .s_mode(s_mode), .c_valid(c_valid), .c_line(c_line), .c_div(c_div)
  );

  cac_div3_pipe #(.LINE_W(LINE_W), .STAGES(DIV_STAGES)) u_div (
    .clk(clk), .rst(rst), .d_valid(c_valid), .d_line(c_line), .d_div(c_div),
    .o_valid(out_valid), .o_line(o_line)
  );

  assign out_addr = {o_line, {LINE_LSB{1'b0}}};

  // In-flight tracking for the latency and ordering checks (R2)
  localparam int CNT_W = $clog2(LATENCY + 2);
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(LATENCY));
  assert_no_orphan_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/chan_addr_compact_test.sv
module chan_addr_compact_test;
  localparam int NCH = 3, NRULE = 8, ADDR_W = 40, CH_W = 37, OFF_W = 14, DIV_STAGES = 4;
  localparam int NENT = NCH * NRULE;
  localparam int LAT  = DIV_STAGES + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0] in_chan = '0;
  logic [2:0] in_rule = '0;
  logic fold_en = 1'b0;
  logic [NENT*OFF_W-1:0] cfg_offset = '0;
  logic [NENT*3-1:0] cfg_remove = '0;
  logic [NENT-1:0] cfg_div3 = '0;
  logic out_valid;
  logic [CH_W-1:0] out_addr;

  chan_addr_compact #(.NCH(NCH), .NRULE(NRULE), .ADDR_W(ADDR_W), .CH_W(CH_W),
                      .OFF_W(OFF_W), .DIV_STAGES(DIV_STAGES)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_chan(in_chan), .in_rule(in_rule), .fold_en(fold_en),
    .cfg_offset(cfg_offset), .cfg_remove(cfg_remove), .cfg_div3(cfg_div3),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [CH_W-1:0] exp_q[$];
  int              cyc_q[$];
  string           tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
      report();
    end
  end

  // Independent behavioural model of the requirements
  function automatic logic [CH_W-1:0] model(input logic [ADDR_W-1:0] a, input int ch, input int rl);
    int e;
    logic [63:0] c, off64;
    logic [2:0] rm;
    e = (((fold_en || ch >= NCH) ? 0 : ch) * NRULE) + rl;
    off64 = {{(64-OFF_W){cfg_offset[e*OFF_W+OFF_W-1]}}, cfg_offset[e*OFF_W +: OFF_W]};
    rm = cfg_remove[e*3 +: 3];
    c = (((64'(a) >> 16) + off64) << 16) | (64'(a) & 64'hffc0);
    if (rm[2]) c = ((c >> 1) & ~64'hff) | (c & 64'hff);
    if (rm[1]) c = ((c >> 1) & ~64'h7f) | (c & 64'h7f);
    if (rm[0]) c = ((c >> 1) & ~64'h3f) | (c & 64'h3f);
    c = c & 64'h1f_ffff_ffff;
    if (cfg_div3[e]) c = (((c >> 6) / 3) << 6) | (c & 64'h3f);
    return c[CH_W-1:0];
  endfunction

  task automatic push(input logic [ADDR_W-1:0] a, input int ch, input int rl, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    in_chan  = 2'(ch);
    in_rule  = 3'(rl);
    exp_q.push_back(model(a, ch, rl));
    cyc_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic set_entry(input int ch, input int rl, input int off, input logic [2:0] rm, input logic dv);
    int e;
    idle(1);
    e = ch * NRULE + rl;
    cfg_offset[e*OFF_W +: OFF_W] = OFF_W'(off);
    cfg_remove[e*3 +: 3] = rm;
    cfg_div3[e] = dv;
  endtask

  task automatic set_fold(input logic f);
    idle(1);
    fold_en = f;
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected output: actual %h expected no result", out_addr);
      end else begin
        logic [CH_W-1:0] e;
        int ec;
        string t;
        e  = exp_q.pop_front();
        ec = cyc_q.pop_front();
        t  = tag_q.pop_front();
        if (out_addr !== e) begin
          fails++;
          $display("FAIL %s address: actual %h expected %h", t, out_addr, e);
        end
        checks++;
        if (cyc != ec) begin
          fails++;
          $display("FAIL R2 latency (%s): actual cycle %0d expected %0d", t, cyc, ec);
        end
      end
    end
  end

  initial begin
    // R1: quiet through reset and just after
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 in reset: actual %b expected 0", out_valid); end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 after reset: actual %b expected 0", out_valid); end

    // R3: offsets, positive, negative and zero
    set_entry(0, 0, 0, 3'b000, 1'b0);
    push(40'h12_3456_7FFF, 0, 0, "R3 zero offset");
    set_entry(0, 1, 5, 3'b000, 1'b0);
    push(40'h01_2345_ABCD, 0, 1, "R3 positive offset");
    set_entry(0, 2, -3, 3'b000, 1'b0);
    push(40'h00_0010_FFC0, 0, 2, "R3 negative offset");
    idle(LAT + 2);

    // R5: wide inputs and a wrapping negative sum are cut to 37 bits
    set_entry(1, 3, 0, 3'b000, 1'b0);
    push(40'hFF_FFFF_FFC0, 1, 3, "R5 cut high bits");
    set_entry(1, 4, -1, 3'b000, 1'b0);
    push(40'h00_0000_1240, 1, 4, "R5 negative wrap");
    idle(LAT + 2);

    // R4: each removal alone, pairs and all three, order matters
    set_entry(2, 0, 0, 3'b100, 1'b0);
    push(40'h00_0000_03C0, 2, 0, "R4 drop bit 8");
    push(40'h0A_5A5A_5A40, 2, 0, "R4 drop bit 8 pattern");
    set_entry(2, 1, 0, 3'b010, 1'b0);
    push(40'h0A_5A5A_5AC0, 2, 1, "R4 drop bit 7");
    set_entry(2, 2, 0, 3'b001, 1'b0);
    push(40'h05_A5A5_A5C0, 2, 2, "R4 drop bit 6");
    set_entry(2, 3, 7, 3'b111, 1'b0);
    push(40'h1F_0F0F_F1C0, 2, 3, "R4 drop all");
    set_entry(2, 4, 0, 3'b101, 1'b0);
    push(40'h00_0000_0540, 2, 4, "R4 drop 8 and 6");
    idle(LAT + 2);

    // R6: divide by 3, including the largest line field
    set_entry(0, 5, 0, 3'b000, 1'b1);
    push(40'h1F_FFFF_FFC0, 0, 5, "R6 max field");
    push(40'h00_0000_00C0, 0, 5, "R6 exact three");
    push(40'h00_0000_0080, 0, 5, "R6 below three");
    set_entry(0, 6, -2, 3'b011, 1'b1);
    push(40'h07_1234_5680, 0, 6, "R6 with drops");
    idle(LAT + 2);

    // R7 and R8: fold mode and out-of-range channel use channel 0
    set_entry(0, 7, 9, 3'b001, 1'b0);
    set_entry(2, 7, -9, 3'b100, 1'b1);
    push(40'h03_3333_3340, 2, 7, "R9 own entry");
    push(40'h03_3333_3340, 3, 7, "R8 channel three");
    set_fold(1'b1);
    push(40'h03_3333_3340, 2, 7, "R7 fold channel two");
    push(40'h03_3333_3340, 1, 7, "R7 fold channel one");
    set_fold(1'b0);
    idle(LAT + 2);

    // R2 and R9: random settings, back-to-back stream then gapped stream
    for (int e = 0; e < NENT; e++) begin
      cfg_offset[e*OFF_W +: OFF_W] = OFF_W'($urandom);
      cfg_remove[e*3 +: 3] = 3'($urandom);
      cfg_div3[e] = 1'($urandom);
    end
    for (int i = 0; i < 48; i++)
      push({8'($urandom), 32'($urandom)}, int'($urandom % 4), int'($urandom % 8), "R2 stream");
    idle(2);
    for (int i = 0; i < 16; i++) begin
      push({8'($urandom), 32'($urandom)}, int'($urandom % 3), int'($urandom % 8), "R9 gapped");
      idle(int'($urandom % 3));
    end
    idle(LAT + 4);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    report();
  end
endmodule